// File: doc/BRIEF.md
# Rising-Edge Interrupt Cause Collector

This block sits beside a serial-bus controller. It turns the controller's twelve level status flags into one interrupt line. Each flag is sampled every clock and compared with its sample from the clock before. A low-to-high change latches a sticky cause bit. A flag that simply stays high never raises a cause a second time.

Software acknowledges a cause by writing a one to its bit position. It enables causes through a separate mask register, which comes out of reset with every bit cleared. The interrupt output is a registered OR of the causes that are enabled.

The sampled flag levels are brought out on their own. Before software unmasks a cause and waits for it, it can check whether the condition it wants is already true.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset, the cause vector, the mask vector and the interrupt output are all zero.
- R2: A source bit that is sampled high at a clock edge, after being sampled low at the previous edge, sets its cause bit at that edge. The bit assignment is: 0 transfer done, 1 transfer ready, 2 read-FIFO ready, 3 write-FIFO ready, 4 read-FIFO empty, 5 read-FIFO full, 6 write-FIFO empty, 7 write-FIFO full, 8 read underflow, 9 read overflow, 10 write underflow, 11 write overflow.
- R3: A source that stays high does not set its cause bit again once that bit has been cleared.
- R4: A clear write clears exactly the cause bits whose data bit is 1. Bits written 0 keep their value.
- R5: A clear write with every data bit set to 1 clears every cause bit.
- R6: If a rising edge and a clear write reach the same bit in the same cycle, the bit ends up set.
- R7: The interrupt output equals the OR of (cause AND mask) as it stood one clock earlier.
- R8: A mask write loads the mask vector at that clock edge. Without a write, the mask holds its value.
- R9: The level output shows each source as sampled at the last clock edge, whatever the cause and mask values are.
- R10: The previous-sample state resets to zero. A source that is already high when reset is released therefore sets its cause bit at the first active clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 12 | Level status flags from the controller |
| clr_wr_i | input | 1 | Clear-write strobe for the cause vector |
| clr_data_i | input | 12 | Clear-write data; a 1 clears that cause bit |
| mask_wr_i | input | 1 | Mask-write strobe |
| mask_data_i | input | 12 | New mask value |
| cause_o | output | 12 | Latched cause vector |
| mask_o | output | 12 | Current mask vector |
| level_o | output | 12 | Sampled source levels |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that the sources are synchronous to `clk` and that strobes are single-cycle pulses sampled at the rising edge. They also assume that no check is meaningful until the internal reset has been released for a clock.

The bench changes every input on the falling edge only, so each rising edge sees stable values. It waits for the reset synchronizer to release before it looks at any result. The collision case is driven by raising a source and writing the clear in the same half-period.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  localparam int unsigned NUM_SRC = 12;

  typedef enum int unsigned {
    SRC_XFER_DONE  = 0,
    SRC_XFER_READY = 1,
    SRC_RD_READY   = 2,
    SRC_WR_READY   = 3,
    SRC_RD_EMPTY   = 4,
    SRC_RD_FULL    = 5,
    SRC_WR_EMPTY   = 6,
    SRC_WR_FULL    = 7,
    SRC_RD_UNDER   = 8,
    SRC_RD_OVER    = 9,
    SRC_WR_UNDER   = 10,
    SRC_WR_OVER    = 11
  } src_pos_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] prev_o,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb begin
    prev_d = src_i;
    rise_o = src_i & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= prev_d;
  end

  assign prev_o = prev_q;

  // R2
  rise_follows_low_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (|rise_o) |=> ((prev_q & $past(rise_o)) == $past(rise_o)));
endmodule

// File: rtl/irq_cause_bit.sv
module irq_cause_bit (
  input  logic clk,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic clr_i,
  output logic cause_o
);
  logic cause_q;
  logic cause_d;
  logic cause_en;

  always_comb begin
    cause_en = rise_i | clr_i;
    cause_d  = cause_q;
    if (clr_i)  cause_d = 1'b0;
    if (rise_i) cause_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       cause_q <= 1'b0;
    else if (cause_en) cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    rise_i |=> cause_q);
  // R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (clr_i && !rise_i) |=> !cause_q);
  // R3
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (!cause_q && !rise_i) |=> !cause_q);
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;
  logic         mask_en;

  always_comb begin
    mask_en = wr_i;
    mask_d  = data_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_q));
  // R8
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_i |=> (mask_q == $past(data_i)));
endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit #(
  parameter int unsigned NSRC       = irq_cause_pkg::NUM_SRC,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            clr_wr_i,
  input  logic [NSRC-1:0] clr_data_i,
  input  logic            mask_wr_i,
  input  logic [NSRC-1:0] mask_data_i,
  output logic [NSRC-1:0] cause_o,
  output logic [NSRC-1:0] mask_o,
  output logic [NSRC-1:0] level_o,
  output logic            irq_o
);
  logic            rst_s_n;
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] clr_vec;
  logic [NSRC-1:0] cause;
  logic [NSRC-1:0] mask;
  logic            irq_q;
  logic            irq_d;

  irq_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk(clk), .rst_ni(rst_n), .rst_no(rst_s_n));

  irq_edge_det #(.W(NSRC)) u_edge (
    .clk(clk), .rst_ni(rst_s_n), .src_i(src_i),
    .prev_o(level_o), .rise_o(rise));

  always_comb begin
    clr_vec = clr_data_i & {NSRC{clr_wr_i}};
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_cause
    irq_cause_bit u_bit (
      .clk(clk), .rst_ni(rst_s_n), .rise_i(rise[g]),
      .clr_i(clr_vec[g]), .cause_o(cause[g]));
  end

  irq_mask_reg #(.W(NSRC)) u_mask (
    .clk(clk), .rst_ni(rst_s_n), .wr_i(mask_wr_i),
    .data_i(mask_data_i), .mask_o(mask));

  always_comb begin
    irq_d = |(cause & mask);
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) irq_q <= 1'b0;
    else          irq_q <= irq_d;
  end

  assign cause_o = cause;
  assign mask_o  = mask;
  assign irq_o   = irq_q;

  // R7
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (|(cause_o & mask_o)) |=> irq_o);
  // R7
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(|(cause_o & mask_o)) |=> !irq_o);
  // R5
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (clr_wr_i && (&clr_data_i) && !(|rise)) |=> (cause_o == '0));
endmodule

// File: tb/tb_irq_cause_unit.sv
module tb_irq_cause_unit;
  localparam int unsigned N = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] src_i;
  logic         clr_wr_i;
  logic [N-1:0] clr_data_i;
  logic         mask_wr_i;
  logic [N-1:0] mask_data_i;
  logic [N-1:0] cause_o;
  logic [N-1:0] mask_o;
  logic [N-1:0] level_o;
  logic         irq_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  irq_cause_unit dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .clr_wr_i(clr_wr_i), .clr_data_i(clr_data_i),
    .mask_wr_i(mask_wr_i), .mask_data_i(mask_data_i),
    .cause_o(cause_o), .mask_o(mask_o), .level_o(level_o), .irq_o(irq_o));

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic [N-1:0] src_val);
    rst_n = 1'b0; src_i = src_val; clr_wr_i = 1'b0; clr_data_i = '0;
    mask_wr_i = 1'b0; mask_data_i = '0;
    step(3);
    rst_n = 1'b1;
    step(4);
  endtask

  task automatic clear_write(input logic [N-1:0] d);
    clr_wr_i = 1'b1; clr_data_i = d;
    step();
    clr_wr_i = 1'b0; clr_data_i = '0;
  endtask

  task automatic t_reset_state();
    chk("R1 cause", cause_o, '0);
    chk("R1 mask", mask_o, '0);
    chk("R1 irq", {11'b0, irq_o}, '0);
  endtask

  task automatic t_rise_sets();
    src_i = 12'h0A5;
    step();
    chk("R2 cause after rise", cause_o, 12'h0A5);
    chk("R9 level", level_o, 12'h0A5);
    step();
    chk("R7 masked irq", {11'b0, irq_o}, '0);
  endtask

  task automatic t_hold_high();
    clear_write(12'hFFF);
    chk("R5 clear all", cause_o, '0);
    step(3);
    chk("R3 held source no reset", cause_o, '0);
    chk("R9 level while cleared", level_o, 12'h0A5);
  endtask

  task automatic t_partial_clear();
    src_i = '0;
    step();
    src_i = 12'h801;
    step();
    chk("R2 bits 0 and 11", cause_o, 12'h801);
    clear_write(12'h001);
    chk("R4 partial clear", cause_o, 12'h800);
  endtask

  task automatic t_mask_irq();
    mask_wr_i = 1'b1; mask_data_i = 12'h800;
    step();
    mask_wr_i = 1'b0; mask_data_i = 12'h0FF;
    chk("R8 mask loaded", mask_o, 12'h800);
    chk("R7 irq lags mask", {11'b0, irq_o}, '0);
    step();
    chk("R7 irq asserted", {11'b0, irq_o}, 12'h001);
    chk("R8 mask held", mask_o, 12'h800);
    clear_write(12'h800);
    chk("R4 cause bit 11 cleared", cause_o, '0);
    chk("R7 irq lags clear", {11'b0, irq_o}, 12'h001);
    step();
    chk("R7 irq dropped", {11'b0, irq_o}, '0);
  endtask

  task automatic t_collision();
    src_i = '0;
    step();
    src_i = 12'h008;
    step();
    src_i = '0;
    step();
    chk("R2 bit 3", cause_o, 12'h008);
    src_i = 12'h008; clr_wr_i = 1'b1; clr_data_i = 12'h008;
    step();
    clr_wr_i = 1'b0; clr_data_i = '0;
    chk("R6 set wins", cause_o, 12'h008);
    clear_write(12'h008);
    chk("R4 later clear", cause_o, '0);
  endtask

  task automatic t_reset_high();
    do_reset(12'h040);
    chk("R10 cause from high at reset", cause_o, 12'h040);
    chk("R1 mask after reset", mask_o, '0);
    chk("R9 level after reset", level_o, 12'h040);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    do_reset('0);
    t_reset_state();
    t_rise_sets();
    t_hold_high();
    t_partial_clear();
    t_mask_irq();
    t_collision();
    t_reset_high();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule